// File: doc/BRIEF.md
# Skip-Sequence Counter

This block is a synchronous counter that holds its state in three flip-flops and steps through the six-value cycle 0, 1, 2, 4, 5, 6 before returning to 0. The codes 3 and 7 never appear in the cycle. The counter moves one step on each rising clock edge where the count enable is high, and keeps its value otherwise. A synchronous active-high reset clears it.

Internally the count is treated as a two-bit field that runs 0 to 2, with a carry into the upper bits. The next state is built from per-bit J/K controls. Each control is derived from the present bit and its target value by the flip-flop excitation rules. The two unused codes have a defined exit, so the counter cannot get stuck outside the cycle. A combinational terminal flag marks the step that wraps from 6 back to 0.

Top module: `skip_seq_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count` is 3'd0 after that edge.
- R2: With `rst` low and `cnt_en` high, each edge moves `count` to its successor in 0 → 1 → 2 → 4 → 5 → 6 → 0, and the cycle repeats without end.
- R3: With `rst` low and `cnt_en` low, an edge leaves `count` unchanged. This includes the unused codes 3 and 7.
- R4: If `count` holds 3 or 7, the next edge with `cnt_en` high and `rst` low gives `count` = 0.
- R5: `last_step` is high exactly when `count` is 6 and `cnt_en` is high. It is combinational, in the same cycle. The edge that follows it brings `count` to 0.
- R6: Reset takes priority over enable: with `rst` and `cnt_en` both high, the edge gives `count` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Advance one step on this edge when high |
| count | output | 3 | Present count value |
| last_step | output | 1 | High while count is 6 and enable is high |

## Verification
The unused codes 3 and 7 are the hard case. No sequence of port activity can reach them, because every path from reset stays inside the six-value cycle. The bench therefore overwrites the state register directly while the enable is low, then releases it. It then checks through `count` that the illegal value is held for one disabled edge and replaced by 0 on the next enabled edge. The same reference model that tracks normal counting also covers these two excursions.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {
        JK_KEEP   = 2'b00,
        JK_CLEAR  = 2'b01,
        JK_SET    = 2'b10,
        JK_FLIP   = 2'b11
    } jk_op_e;

    function automatic logic jk_apply(input jk_op_e op, input logic q);
        logic r;
        case (op)
            JK_KEEP:  r = q;
            JK_CLEAR: r = 1'b0;
            JK_SET:   r = 1'b1;
            default:  r = ~q;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ssc_succ.sv
// Successor logic: low two bits count 0..2, the upper field carries and wraps.
module ssc_succ #(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             adv,
    output logic [WIDTH-1:0] tgt
);
    localparam int LOW_W = 2;
    localparam int HI_W  = WIDTH - LOW_W;
    localparam logic [LOW_W-1:0] LOW_TOP  = 2'd2;
    localparam logic [LOW_W-1:0] LOW_SKIP = 2'd3;

    logic [LOW_W-1:0] low_cur;
    logic [HI_W-1:0]  hi_cur;

    always_comb begin
        low_cur = cur[LOW_W-1:0];
        hi_cur  = cur[WIDTH-1:LOW_W];
        tgt     = cur;
        if (adv) begin
            if (low_cur == LOW_SKIP) begin
                tgt = '0;
            end else if (low_cur == LOW_TOP) begin
                tgt = {hi_cur + HI_W'(1), {LOW_W{1'b0}}};
            end else begin
                tgt = {hi_cur, low_cur + LOW_W'(1)};
            end
        end
    end
endmodule

// File: rtl/ssc_jk_excite.sv
// Per-bit J/K from present and target bits, using the excitation rules.
module ssc_jk_excite #(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0] q,
    input  logic [WIDTH-1:0] tgt,
    output logic [WIDTH-1:0] j,
    output logic [WIDTH-1:0] k
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // present 0: J carries the target, K unused
        // present 1: K carries the inverted target, J unused
        assign j[b] = ~q[b] & tgt[b];
        assign k[b] =  q[b] & ~tgt[b];
    end
endmodule

// File: rtl/ssc_jk_cell.sv
module ssc_jk_cell (
    input  logic j,
    input  logic k,
    input  logic q,
    output logic q_nxt
);
    import ssc_pkg::*;

    jk_op_e op;

    always_comb begin
        op    = jk_op_e'({j, k});
        q_nxt = jk_apply(op, q);
    end
endmodule

// File: rtl/skip_seq_counter.sv
module skip_seq_counter #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    output logic [WIDTH-1:0] count,
    output logic             last_step
);
    localparam int LOW_W = 2;
    localparam logic [WIDTH-1:0] LAST_CODE = {{(WIDTH-LOW_W){1'b1}}, 2'b10};

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic [WIDTH-1:0] jv;
        logic [WIDTH-1:0] kv;
    } nxt_t;

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] tgt_w;
    logic [WIDTH-1:0] j_w;
    logic [WIDTH-1:0] k_w;
    logic [WIDTH-1:0] bit_nxt_w;
    nxt_t             nxt_d;

    ssc_succ #(.WIDTH(WIDTH)) succ_i (
        .cur (cnt_q),
        .adv (cnt_en),
        .tgt (tgt_w)
    );

    ssc_jk_excite #(.WIDTH(WIDTH)) excite_i (
        .q   (cnt_q),
        .tgt (tgt_w),
        .j   (j_w),
        .k   (k_w)
    );

    for (genvar b = 0; b < WIDTH; b++) begin : g_cell
        ssc_jk_cell cell_i (
            .j     (j_w[b]),
            .k     (k_w[b]),
            .q     (cnt_q[b]),
            .q_nxt (bit_nxt_w[b])
        );
    end

    always_comb begin
        nxt_d.jv  = j_w;
        nxt_d.kv  = k_w;
        nxt_d.cnt = bit_nxt_w;
        if (rst) begin
            nxt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= nxt_d.cnt;
    end

    assign count     = cnt_q;
    assign last_step = cnt_en & (cnt_q == LAST_CODE);
endmodule

// File: rtl/ssc_chk.sv
module ssc_chk #(
    parameter int WIDTH = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic [WIDTH-1:0] count,
    input logic             last_step
);
    function automatic logic [WIDTH-1:0] exp_succ(input logic [WIDTH-1:0] v);
        logic [WIDTH-1:0] r;
        if (v[1:0] == 2'd2) r = (v + WIDTH'(2));
        else                r = v + WIDTH'(1);
        return r;
    endfunction

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (count == '0)); // R1

    AST_RESET_OVER_EN: assert property (@(posedge clk)
        (rst && cnt_en) |=> (count == '0)); // R6

    AST_STEP_SEQ: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && count[1:0] != 2'b11)
        |=> (count == exp_succ($past(count)) || count[1:0] == 2'b11)); // R2

    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en) |=> (count == $past(count) || count[1:0] == 2'b11)); // R3

    AST_ESCAPE_UNUSED: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && count[1:0] == 2'b11) |=> (count == '0)); // R4

    AST_FLAG_WRAPS: assert property (@(posedge clk) disable iff (rst)
        last_step |=> (count == '0)); // R5

    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        last_step |-> cnt_en); // R5
endmodule

bind skip_seq_counter ssc_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .count     (count),
    .last_step (last_step)
);

// File: tb/skip_seq_counter_tb_top.sv
`timescale 1ns/1ps
module skip_seq_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [2:0] count;
    logic       last_step;

    int checks = 0;
    int failures = 0;
    int model = 0;
    string tag = "R1";
    bit done = 1'b0;

    int seq_list[$] = '{0, 1, 2, 4, 5, 6};

    always #2 clk = ~clk;

    skip_seq_counter dut_i (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .count     (count),
        .last_step (last_step)
    );

    function automatic int ref_next(input int v);
        for (int i = 0; i < seq_list.size(); i++) begin
            if (seq_list[i] == v) return seq_list[(i + 1) % seq_list.size()];
        end
        return 0;
    endfunction

    // reference model, updated on each edge from the inputs applied
    always @(posedge clk) begin
        if (rst && cnt_en)                    tag = "R6";
        else if (rst)                         tag = "R1";
        else if (!cnt_en)                     tag = "R3";
        else if (model == 3 || model == 7)    tag = "R4";
        else                                  tag = "R2";
        if (rst)          model = 0;
        else if (cnt_en)  model = ref_next(model);
    end

    // compare every cycle, away from the edge
    always @(negedge clk) begin
        #1;
        if (!done) begin
            checks++;
            if (count !== 3'(model)) begin
                failures++;
                $display("FAIL %s count actual=%0d expected=%0d at %0t", tag, count, model, $time);
            end
            checks++;
            if (last_step !== (cnt_en && model == 6)) begin
                failures++;
                $display("FAIL R5 last_step actual=%0b expected=%0b at %0t",
                         last_step, (cnt_en && model == 6), $time);
            end
        end
    end

    task automatic step(input bit r, input bit e, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst = r;
            cnt_en = e;
        end
    endtask

    task automatic inject(input logic [2:0] v);
        @(negedge clk);
        rst = 1'b0;
        cnt_en = 1'b0;
        force dut_i.cnt_q = v;
        model = int'(v);
        #0.5;
        release dut_i.cnt_q;
    endtask

    initial begin
        step(1, 0, 3);                 // R1 reset
        step(0, 1, 12);                // R2 two full cycles
        step(0, 0, 3);                 // R3 hold
        step(0, 1, 2);
        for (int i = 0; i < 8; i++) step(0, i % 2, 1);   // R2/R3 alternating
        step(0, 1, 3);
        step(1, 1, 2);                 // R6 reset beats enable
        step(0, 1, 5);                 // reach 6
        step(0, 0, 2);                 // R5 flag low while held at 6
        step(0, 1, 2);                 // R5 wrap
        inject(3'd3);                  // R4 unused code 3
        step(0, 0, 2);                 // R3 held at 3
        step(0, 1, 3);                 // R4 escape to 0
        inject(3'd7);                  // R4 unused code 7
        step(0, 0, 1);
        step(0, 1, 8);
        step(0, 0, 2);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog R2 actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule